// File: doc/BRIEF.md
# Interleaved Thread Slot Scheduler

This block decides, on every clock cycle, which of several hardware threads may issue into a pipeline that all of them share. It supports three policies, chosen by a two-bit select. The first is a fixed rotation in which every thread owns one cycle in turn. The second walks a programmable table of slots, where each slot names a thread. The third is a ready-driven pick that rotates fairly among the threads that are able to issue.

In the two rotation policies, the owner of a slot never changes because its thread is stalled. A stalled owner turns its slot into a pipeline bubble, so the issue timing of every thread stays fixed and can be predicted. The ready-driven policy gives up that property and avoids wasted cycles instead. Software changes the table through a single-entry write port. The outputs are combinational on the current ready bits and on registered rotation state, so the pipeline sees the decision in the same cycle.

Top module: `thread_issue_sched`

## Requirements
- R1: In every cycle, exactly one of `issue_valid` and `bubble` is high.
- R2: With policy code 0 (fixed rotation; code 3 behaves the same), `thread_id` steps 0, 1, …, N-1 and then wraps back to 0, advancing one step per cycle.
- R3: In both rotation policies (codes 0 and 1), an owner whose ready bit is low produces a bubble. In that cycle `thread_id` still names the owner, no other thread issues, and the rotation still advances.
- R4: After reset, table slot i holds thread i mod N.
- R5: With policy code 1 (table), the slot index steps 0 through S-1 and wraps. `thread_id` is the entry stored in the current slot.
- R6: A table write (`cfg_we` with slot and thread ID) is stored at the clock edge. A read of the same slot in the cycle of the write still returns the old entry. The new entry is used on the next visit to that slot.
- R7: With policy code 2 (ready-driven), the block issues the first ready thread found by searching upward, with wrap, from the thread after the last one that issued in any policy. After reset, the last issuer is taken to be N-1.
- R8: With policy code 2 and no thread ready, the block outputs a bubble with `thread_id` = 0.
- R9: In the first cycle after the policy select changes, the rotation restarts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_ready | input | N_THREADS | Per-thread ready-to-issue bits |
| policy | input | 2 | 0 fixed rotation, 1 slot table, 2 ready-driven, 3 same as 0 |
| cfg_we | input | 1 | Slot-table write strobe |
| cfg_slot | input | log2(N_SLOTS) | Table slot to write |
| cfg_tid | input | log2(N_THREADS) | Thread ID written into the slot |
| issue_valid | output | 1 | A thread issues this cycle |
| thread_id | output | log2(N_THREADS) | Slot owner, or the picked thread |
| bubble | output | 1 | No issue this cycle |

## Verification
A rotation pointer that is wrong shows up at once as an out-of-sequence `thread_id` in the same cycle. Depending on the ready bits, it can also turn an issue into a bubble or a bubble into an issue. A table entry that is corrupted stays hidden until the rotation reaches that slot, which takes up to S cycles. Because of this, the stimulus walks a full table lap after the writes. A wrong last-issuer register only shows in ready-driven mode when two or more threads are ready, so the vectors keep several threads ready across consecutive picks.

// File: rtl/tis_pkg.sv
package tis_pkg;
   typedef enum logic [1:0] {
      POL_FIXED = 2'd0,
      POL_TABLE = 2'd1,
      POL_READY = 2'd2,
      POL_RSVD  = 2'd3
   } policy_e;
endpackage

// File: rtl/tis_slot_table.sv
module tis_slot_table #(
   parameter int N_THREADS = 8,
   parameter int N_SLOTS   = 16,
   parameter int TID_W     = $clog2(N_THREADS),
   parameter int SLOT_W    = $clog2(N_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [TID_W-1:0]  wr_tid,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [TID_W-1:0]  rd_tid
);
   logic [TID_W-1:0] ent [N_SLOTS];

   // one register per slot; reset pattern is slot index modulo thread count
   for (genvar g = 0; g < N_SLOTS; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent[g] <= TID_W'(g % N_THREADS);
         else if (wr_en && (wr_slot == SLOT_W'(g)))
            ent[g] <= wr_tid;
      end
   end

   assign rd_tid = ent[rd_slot];

   // R6: a write is present in the table one cycle later
   a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ent[$past(wr_slot)] == $past(wr_tid));
endmodule

// File: rtl/tis_rotor.sv
module tis_rotor
   import tis_pkg::*;
#(
   parameter int N_THREADS = 8,
   parameter int N_SLOTS   = 16,
   parameter int SLOT_W    = $clog2(N_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        policy,
   output logic [SLOT_W-1:0] cur_slot
);
   localparam logic [SLOT_W:0] SPAN_TBL = (SLOT_W+1)'(N_SLOTS);
   localparam logic [SLOT_W:0] SPAN_FIX = (SLOT_W+1)'(N_THREADS);

   logic [SLOT_W-1:0] ptr_q;
   logic [1:0]        pol_q;
   logic [SLOT_W:0]   span;
   logic              at_end;

   always_comb begin
      cur_slot = (policy != pol_q) ? '0 : ptr_q;
      span     = (policy_e'(policy) == POL_TABLE) ? SPAN_TBL : SPAN_FIX;
      at_end   = ({1'b0, cur_slot} == (span - 1'b1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         pol_q <= POL_FIXED;
      end else begin
         ptr_q <= at_end ? '0 : cur_slot + 1'b1;
         pol_q <= policy;
      end
   end

   // R9: a new policy starts its rotation at slot 0
   a_r9_restart_slot0: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && policy != $past(policy)) |-> cur_slot == '0);

   // R5: table walk steps by one and wraps at the last slot
   a_r5_table_walk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && policy == $past(policy) && policy_e'(policy) == POL_TABLE)
      |-> cur_slot == (($past(cur_slot) == SLOT_W'(N_SLOTS-1)) ? '0 : $past(cur_slot) + 1'b1));
endmodule

// File: rtl/tis_rr_pick.sv
module tis_rr_pick #(
   parameter int N_THREADS = 8,
   parameter int TID_W     = $clog2(N_THREADS)
) (
   input  logic [N_THREADS-1:0] ready,
   input  logic [TID_W-1:0]     last,
   output logic                 found,
   output logic [TID_W-1:0]     pick
);
   logic [TID_W-1:0] idx;

   // search upward from the thread after the last issuer, with wrap
   always_comb begin
      found = 1'b0;
      pick  = '0;
      idx   = '0;
      for (int k = 1; k <= N_THREADS; k++) begin
         idx = last + TID_W'(k);
         if (!found && ready[idx]) begin
            found = 1'b1;
            pick  = idx;
         end
      end
   end

   // R7: a picked thread is always ready; R8: nothing found only when idle
   always_comb begin
      a_r7_pick_ready: assert (!found || ready[pick]);
      a_r8_found_any:  assert (found == (|ready));
   end
endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched
   import tis_pkg::*;
#(
   parameter int N_THREADS = 8,
   parameter int N_SLOTS   = 16,
   parameter int TID_W     = $clog2(N_THREADS),
   parameter int SLOT_W    = $clog2(N_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_THREADS-1:0] thr_ready,
   input  logic [1:0]           policy,
   input  logic                 cfg_we,
   input  logic [SLOT_W-1:0]    cfg_slot,
   input  logic [TID_W-1:0]     cfg_tid,
   output logic                 issue_valid,
   output logic [TID_W-1:0]     thread_id,
   output logic                 bubble
);
   // elaboration-time parameter checks
   if (N_THREADS < 2 || (N_THREADS & (N_THREADS - 1)) != 0) begin : g_bad_threads
      $error("N_THREADS must be a power of two, at least 2");
   end
   if (N_SLOTS < N_THREADS || (N_SLOTS & (N_SLOTS - 1)) != 0) begin : g_bad_slots
      $error("N_SLOTS must be a power of two, not below N_THREADS");
   end

   logic [SLOT_W-1:0] cur_slot;
   logic [TID_W-1:0]  tbl_tid;
   logic [TID_W-1:0]  last_q;
   logic              rr_found;
   logic [TID_W-1:0]  rr_pick;
   logic [TID_W-1:0]  owner;
   logic              go;
   policy_e           pol;

   assign pol = policy_e'(policy);

   tis_rotor #(.N_THREADS(N_THREADS), .N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) u_rotor (
      .clk(clk), .rst_n(rst_n), .policy(policy), .cur_slot(cur_slot));

   tis_slot_table #(.N_THREADS(N_THREADS), .N_SLOTS(N_SLOTS), .TID_W(TID_W), .SLOT_W(SLOT_W)) u_table (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_slot(cfg_slot), .wr_tid(cfg_tid),
      .rd_slot(cur_slot), .rd_tid(tbl_tid));

   tis_rr_pick #(.N_THREADS(N_THREADS), .TID_W(TID_W)) u_pick (
      .ready(thr_ready), .last(last_q), .found(rr_found), .pick(rr_pick));

   always_comb begin
      unique case (pol)
         POL_TABLE: begin owner = tbl_tid;                    go = thr_ready[tbl_tid]; end
         POL_READY: begin owner = rr_found ? rr_pick : '0;    go = rr_found;           end
         default:   begin owner = cur_slot[TID_W-1:0];        go = thr_ready[cur_slot[TID_W-1:0]]; end
      endcase
   end

   assign issue_valid = go;
   assign bubble      = ~go;
   assign thread_id   = owner;

   // last issuer, tracked in every policy
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   last_q <= TID_W'(N_THREADS - 1);
      else if (go)  last_q <= owner;
   end

   // R1: issue and bubble are exclusive and one is always set
   a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({issue_valid, bubble}));

   // R2: fixed rotation advances the thread by one each cycle
   a_r2_fixed_step: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && policy == $past(policy) && (pol == POL_FIXED || pol == POL_RSVD))
      |-> thread_id == $past(thread_id) + 1'b1);

   // R3: in rotation policies the slot owner alone decides issue
   a_r3_owner_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (pol != POL_READY) |-> issue_valid == thr_ready[thread_id]);

   // R8: idle ready-driven cycle reports thread 0 as a bubble
   a_r8_idle_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      (pol == POL_READY && thr_ready == '0) |-> (bubble && thread_id == '0));

   // R7: with several ready threads, back-to-back picks differ
   a_r7_rotate: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && pol == POL_READY && $past(issue_valid) && $countones(thr_ready) >= 2)
      |-> thread_id != $past(thread_id));
endmodule

// File: tb/thread_issue_sched_tb.sv
module thread_issue_sched_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 39;

   typedef struct packed {
      logic [1:0] pol;
      logic [7:0] rdy;
      logic       we;
      logic [3:0] ws;
      logic [2:0] wt;
      logic       ev;
      logic [2:0] et;
      logic [3:0] req;
   } vec_t;

   // R2 fixed lap, R3 bubble, R7/R8 ready-driven, R9 switch, R6 write timing, R5 table lap
   localparam vec_t VEC [NV] = '{
      '{2'd0, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd0, 4'd2},
      '{2'd0, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd1, 4'd2},
      '{2'd0, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd2, 4'd2},
      '{2'd0, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd3, 4'd2},
      '{2'd0, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd4, 4'd2},
      '{2'd0, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd5, 4'd2},
      '{2'd0, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd6, 4'd2},
      '{2'd0, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd7, 4'd2},
      '{2'd0, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd0, 4'd2},
      '{2'd0, 8'hFD, 1'b0, 4'd0, 3'd0, 1'b0, 3'd1, 4'd3},
      '{2'd0, 8'hFD, 1'b0, 4'd0, 3'd0, 1'b1, 3'd2, 4'd3},
      '{2'd2, 8'h14, 1'b0, 4'd0, 3'd0, 1'b1, 3'd4, 4'd7},
      '{2'd2, 8'h14, 1'b0, 4'd0, 3'd0, 1'b1, 3'd2, 4'd7},
      '{2'd2, 8'h00, 1'b0, 4'd0, 3'd0, 1'b0, 3'd0, 4'd8},
      '{2'd2, 8'h81, 1'b0, 4'd0, 3'd0, 1'b1, 3'd7, 4'd7},
      '{2'd2, 8'h81, 1'b0, 4'd0, 3'd0, 1'b1, 3'd0, 4'd7},
      '{2'd2, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd1, 4'd7},
      '{2'd1, 8'hFF, 1'b1, 4'd3, 3'd6, 1'b1, 3'd0, 4'd9},
      '{2'd1, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd1, 4'd5},
      '{2'd1, 8'hFF, 1'b1, 4'd2, 3'd5, 1'b1, 3'd2, 4'd6},
      '{2'd1, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd6, 4'd6},
      '{2'd1, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd4, 4'd5},
      '{2'd1, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd5, 4'd5},
      '{2'd1, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd6, 4'd5},
      '{2'd1, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd7, 4'd5},
      '{2'd1, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd0, 4'd4},
      '{2'd1, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd1, 4'd4},
      '{2'd1, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd2, 4'd4},
      '{2'd1, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd3, 4'd4},
      '{2'd1, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd4, 4'd4},
      '{2'd1, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd5, 4'd4},
      '{2'd1, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd6, 4'd4},
      '{2'd1, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd7, 4'd5},
      '{2'd1, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd0, 4'd5},
      '{2'd1, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd1, 4'd5},
      '{2'd1, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd5, 4'd6},
      '{2'd1, 8'hBF, 1'b0, 4'd0, 3'd0, 1'b0, 3'd6, 4'd3},
      '{2'd0, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd0, 4'd9},
      '{2'd0, 8'hFF, 1'b0, 4'd0, 3'd0, 1'b1, 3'd1, 4'd2}
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] thr_ready;
   logic [1:0] policy;
   logic       cfg_we;
   logic [3:0] cfg_slot;
   logic [2:0] cfg_tid;
   logic       issue_valid;
   logic [2:0] thread_id;
   logic       bubble;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   thread_issue_sched u_dut (
      .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready), .policy(policy),
      .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_tid(cfg_tid),
      .issue_valid(issue_valid), .thread_id(thread_id), .bubble(bubble));

   // compares all three outputs; R1 is checked on every call
   task automatic chk(input string req, input logic ev, input logic [2:0] et);
      checks++;
      if (issue_valid !== ev || bubble !== ~ev || thread_id !== et) begin
         fails++;
         $display("FAIL %s: valid=%b bubble=%b tid=%0d expected valid=%b bubble=%b tid=%0d (R1 pairing)",
                  req, issue_valid, bubble, thread_id, ev, ~ev, et);
      end
   endtask

   task automatic drive(input logic [1:0] p, input logic [7:0] r,
                        input logic we, input logic [3:0] ws, input logic [2:0] wt);
      policy = p; thr_ready = r; cfg_we = we; cfg_slot = ws; cfg_tid = wt;
   endtask

   initial begin
      rst_n = 1'b0;
      drive(2'd0, 8'h00, 1'b0, 4'd0, 3'd0);
      repeat (3) @(negedge clk);
      #1 chk("R1 reset", 1'b0, 3'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].pol, VEC[i].rdy, VEC[i].we, VEC[i].ws, VEC[i].wt);
         #1 chk($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].ev, VEC[i].et);
         @(negedge clk);
      end

      // R4: reset restores the table (slots 2 and 3 were rewritten above)
      rst_n = 1'b0;
      drive(2'd1, 8'hFF, 1'b0, 4'd0, 3'd0);
      #1 chk("R4 in reset", 1'b1, 3'd0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int s = 0; s < 4; s++) begin
         #1 chk($sformatf("R4 slot%0d", s), 1'b1, 3'(s));
         @(negedge clk);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule